// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block gathers the data bytes of one serial write command into a page-sized holding latch and then moves them into a byte-array model during a single self-timed write cycle. A serial front end (outside this block) announces a command with a start pulse and address. It then presents each completed data byte with a strobe. When chip select goes high, it reports that event along with a flag that tells whether the last received bit closed a whole byte. A separate protection stage supplies a write-enable flag and a flag marking the target as protected.

The byte pointer advances only inside the page that the start address selected. After the last byte of that page it returns to the page's first byte, and a later byte replaces an earlier one in the latch. Only the offsets that received a byte are written to the array. A commit starts a busy period of a fixed number of clocks. During that period new commands, bytes and chip-select events have no effect, and the read port returns zero. When the period ends, a one-clock done pulse tells the enable latch elsewhere to clear.

The array model holds 2**ADDR_W bytes. With ADDR_W = 15 it covers the full 32768-byte space. The default is smaller to keep elaboration light.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy and done are 0 and every array byte reads 0x00.
- R2: A committed command stores its k-th data byte (k counted from 0) at the byte address whose page field (address bits ADDR_W-1..6) equals that of the start address and whose offset (bits 5..0) is the start offset plus k, taken modulo 64.
- R3: The offset never carries into the page field. A command that runs past offset 63 continues at offset 0 of the same page. When more than 64 bytes are sent, the last byte sent to an offset is the one stored there.
- R4: Array bytes whose offsets received no data in the command keep their previous contents. This includes bytes of the same page.
- R5: A commit starts only when cs_rise arrives while a command is open, at least one byte has been received and cs_on_boundary is 1. In every other case the command is discarded, busy stays 0 and the array is unchanged.
- R6: A commit also requires wr_en = 1 and prot_hit = 0 at the cs_rise cycle. If either condition fails, the command is discarded with no busy period.
- R7: busy rises in the clock after an accepted cs_rise and stays 1 for exactly WC_CYCLES clocks. The array update and a one-clock done pulse appear in the first clock after busy falls.
- R8: While busy is 1, cmd_start, byte_vld and cs_rise are ignored, so no later commit follows from them. During that time rd_data reads 0x00.
- R9: Address bit 15, and every bit from ADDR_W upward, is ignored for both writing and reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Opens a new write command |
| start_addr | input | 16 | Start byte address of the command |
| byte_vld | input | 1 | A data byte has been received |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select has gone high |
| cs_on_boundary | input | 1 | cs_rise came right after a byte's last bit |
| wr_en | input | 1 | Write enable latch state |
| prot_hit | input | 1 | Target page lies in a protected region |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (0 while busy) |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-clock pulse at the end of the write cycle |

## Verification
The commit path is tried with several patterns. A short run in mid-page separates correct placement from an off-by-one pointer. A run that starts two bytes before a page end separates wrapping from a carry into the next page. A 66-byte run shows that later bytes replace earlier ones in the latch. A one-byte rewrite inside an already written region shows that untouched neighbours keep their data. The gate is probed with an off-boundary chip-select rise, a command with no bytes, a cleared enable and a protected target; each must leave busy low and the array unchanged. Traffic sent during a running cycle, together with a read issued at the same time, separates true lockout from a queued second commit. Addresses with bit 15 or aliased upper bits set show that those bits are dropped.

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64,
  parameter int WC_CYCLES  = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [15:0] start_addr,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        cs_rise,
  input  logic        cs_on_boundary,
  input  logic        wr_en,
  input  logic        prot_hit,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        done
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WC_CYCLES - 1);

  logic [7:0]            mem   [DEPTH];
  logic [7:0]            latch [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] lvalid;
  logic [PG_W-1:0]       page_q;
  logic [OFS_W-1:0]      ofs_q;
  logic                  open_q, got_q, busy_q, done_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  commit_ok;

  assign commit_ok = cs_rise && open_q && got_q && cs_on_boundary
                   && wr_en && !prot_hit && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) latch[i] <= '0;
      lvalid <= '0;
      page_q <= '0;
      ofs_q  <= '0;
      open_q <= 1'b0;
      got_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          for (int i = 0; i < PAGE_BYTES; i++)
            if (lvalid[i]) mem[{page_q, OFS_W'(i)}] <= latch[i];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cs_rise) begin
        open_q <= 1'b0;
        if (commit_ok) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cmd_start) begin
        open_q <= 1'b1;
        got_q  <= 1'b0;
        lvalid <= '0;
        page_q <= start_addr[ADDR_W-1:OFS_W];
        ofs_q  <= start_addr[OFS_W-1:0];
      end else if (byte_vld && open_q) begin
        latch[ofs_q]  <= byte_data;
        lvalid[ofs_q] <= 1'b1;
        ofs_q         <= ofs_q + 1'b1;
        got_q         <= 1'b1;
      end
    end
  end

  assign rd_data = busy_q ? 8'h00 : mem[rd_addr[ADDR_W-1:0]];
  assign busy    = busy_q;
  assign done    = done_q;

  p_busy_needs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cs_rise && cs_on_boundary && wr_en && !prot_hit));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_LAST));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_latch_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(lvalid) && $stable(page_q) && $stable(ofs_q)));

  p_no_open_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !open_q);
endmodule

// File: tb/sim_page_commit_ctrl.sv
module sim_page_commit_ctrl;
  localparam int WC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [15:0] start_addr = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        cs_rise = 1'b0;
  logic        cs_on_boundary = 1'b0;
  logic        wr_en = 1'b1;
  logic        prot_hit = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  page_commit_ctrl #(.ADDR_W(10), .PAGE_BYTES(64), .WC_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_on_boundary(cs_on_boundary), .wr_en(wr_en), .prot_hit(prot_hit),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input int exp);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic send_cmd(input logic [15:0] a, input int n, input logic [7:0] seed);
    @(negedge clk);
    cmd_start = 1'b1; start_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = seed + 8'(i);
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic cs_end(input logic bnd);
    cs_rise = 1'b1; cs_on_boundary = bnd;
    @(negedge clk);
    cs_rise = 1'b0; cs_on_boundary = 1'b0;
  endtask

  task automatic wait_commit(input string req);
    int n = 0;
    while (busy && n < 10 * WC) begin
      n++;
      @(negedge clk);
    end
    check({req, " busy length"}, n, WC);
    check({req, " done pulse"}, int'(done), 1);
    @(negedge clk);
    check({req, " done single"}, int'(done), 0);
  endtask

  task automatic no_busy(input string req);
    int seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (busy) seen++;
      @(negedge clk);
    end
    check({req, " no busy"}, seen, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rd_chk("R1 array", 16'h0105, 8'h00);
    rd_chk("R1 array", 16'h03FF, 8'h00);
  endtask

  task automatic t_basic;
    send_cmd(16'h0105, 3, 8'hA0);
    cs_end(1'b1);
    wait_commit("R7 basic");
    rd_chk("R2 byte0", 16'h0105, 8'hA0);
    rd_chk("R2 byte1", 16'h0106, 8'hA1);
    rd_chk("R2 byte2", 16'h0107, 8'hA2);
    rd_chk("R4 below", 16'h0104, 8'h00);
    rd_chk("R4 above", 16'h0108, 8'h00);
  endtask

  task automatic t_partial;
    send_cmd(16'h0106, 1, 8'h55);
    cs_end(1'b1);
    wait_commit("R7 partial");
    rd_chk("R4 kept lo", 16'h0105, 8'hA0);
    rd_chk("R2 rewrite", 16'h0106, 8'h55);
    rd_chk("R4 kept hi", 16'h0107, 8'hA2);
  endtask

  task automatic t_wrap;
    send_cmd(16'h00BE, 4, 8'h10);
    cs_end(1'b1);
    wait_commit("R7 wrap");
    rd_chk("R3 ofs62", 16'h00BE, 8'h10);
    rd_chk("R3 ofs63", 16'h00BF, 8'h11);
    rd_chk("R3 wrap0", 16'h0080, 8'h12);
    rd_chk("R3 wrap1", 16'h0081, 8'h13);
    rd_chk("R3 no carry", 16'h00C0, 8'h00);
  endtask

  task automatic t_overrun;
    send_cmd(16'h0240, 66, 8'h00);
    cs_end(1'b1);
    wait_commit("R7 overrun");
    rd_chk("R3 replaced0", 16'h0240, 8'h40);
    rd_chk("R3 replaced1", 16'h0241, 8'h41);
    rd_chk("R3 kept2", 16'h0242, 8'h02);
    rd_chk("R3 last", 16'h027F, 8'h3F);
    rd_chk("R3 next page", 16'h0280, 8'h00);
  endtask

  task automatic t_discard;
    send_cmd(16'h0300, 2, 8'h77);
    cs_end(1'b0);
    no_busy("R5 off boundary");
    rd_chk("R5 off boundary array", 16'h0300, 8'h00);
    send_cmd(16'h0302, 0, 8'h00);
    cs_end(1'b1);
    no_busy("R5 zero bytes");
    rd_chk("R5 zero bytes array", 16'h0302, 8'h00);
  endtask

  task automatic t_gate;
    wr_en = 1'b0;
    send_cmd(16'h0310, 1, 8'h66);
    cs_end(1'b1);
    no_busy("R6 wr_en low");
    rd_chk("R6 wr_en low array", 16'h0310, 8'h00);
    wr_en = 1'b1; prot_hit = 1'b1;
    send_cmd(16'h0311, 1, 8'h67);
    cs_end(1'b1);
    no_busy("R6 protected");
    rd_chk("R6 protected array", 16'h0311, 8'h00);
    prot_hit = 1'b0;
  endtask

  task automatic t_lockout;
    int n = 0;
    send_cmd(16'h0320, 1, 8'h99);
    cs_end(1'b1);
    check("R7 busy after rise", int'(busy), 1);
    rd_chk("R8 read blocked", 16'h0105, 8'h00);
    send_cmd(16'h0330, 1, 8'hEE);
    cs_end(1'b1);
    check("R8 still busy", int'(busy), 1);
    while (busy && n < 10 * WC) begin
      n++;
      @(negedge clk);
    end
    check("R7 done after lockout", int'(done), 1);
    rd_chk("R8 committed", 16'h0320, 8'h99);
    rd_chk("R8 ignored write", 16'h0330, 8'h00);
    rd_chk("R8 read restored", 16'h0105, 8'hA0);
    no_busy("R8 no second commit");
  endtask

  task automatic t_msb;
    send_cmd(16'h8010, 1, 8'h3C);
    cs_end(1'b1);
    wait_commit("R7 msb");
    rd_chk("R9 bit15 write", 16'h0010, 8'h3C);
    rd_chk("R9 bit15 read", 16'h8010, 8'h3C);
    send_cmd(16'h0410, 1, 8'h5A);
    cs_end(1'b1);
    wait_commit("R7 alias");
    rd_chk("R9 upper bits", 16'h0010, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_wrap();
    t_overrun();
    t_discard();
    t_gate();
    t_lockout();
    t_msb();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(10 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule